// File: doc/BRIEF.md
# Zero-Crossing Timeout Watchdog

This block watches the zero-crossing strobes that come from a line-voltage channel. It raises a sticky status flag when no strobe arrives within a programmable number of timebase ticks. An external source supplies the timebase tick, so one unit of the 12-bit timeout register equals one tick. With the register at its largest value, the window is about 0.15 s. A host writes the timeout through a single-cycle write strobe and can read the stored value back at any time.

Every crossing reloads an internal down-counter from the timeout register. A register write also reloads the counter, using the value being written. The counter steps down once per tick. When the window runs out, the status flag is set once. The counter then rests at zero until the next reload. The status flag records the event even while the interrupt enable is low. The enable only masks the active-low interrupt line, and the host clears the flag with a clear strobe.

Top module: `zc_timeout_watchdog`

## Requirements
- R1: After reset the stored timeout reads 0xFFF, the status is 0 and the interrupt line is 1. The counter starts loaded with 0xFFF and armed.
- R2: A cycle with `tmo_wr_i` high stores `tmo_wdata_i`, and `tmo_rdata_o` shows it after that clock edge.
- R3: With a timeout of N ≥ 1, the status rises at the edge of the Nth tick after a reload. Any reload before the Nth tick restarts the count, so crossings spaced closer than N ticks never set the status.
- R4: With a timeout of 0, the first tick after a reload sets the status.
- R5: One expiry sets the status once. Once cleared, the status stays 0 until a reload and a new full window have passed, because the counter holds at zero in between.
- R6: A register write restarts the window at once with the written value, even in the middle of a count.
- R7: The status is set on expiry whatever the value of `irq_en_i`.
- R8: `irq_n_o` equals NOT(status AND `irq_en_i`) and follows `irq_en_i` within the same cycle.
- R9: A cycle with `stat_clr_i` high drops the status at that clock edge, and `irq_n_o` returns to 1 with it. If an expiry happens in the same cycle as the clear, the set wins.
- R10: If a write and a crossing arrive in the same cycle, the counter loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one count per high cycle |
| zc_i | input | 1 | Zero-crossing strobe |
| tmo_wr_i | input | 1 | Timeout register write strobe |
| tmo_wdata_i | input | 12 | Timeout value to write |
| tmo_rdata_o | output | 12 | Stored timeout value |
| irq_en_i | input | 1 | Interrupt enable for the timeout event |
| stat_clr_i | input | 1 | Clears the sticky status |
| stat_o | output | 1 | Sticky timeout status |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions watch properties that hold on every cycle. Each write must land in both the register and the counter. An idle counter stays at zero. An expiry must raise the status, a clear without an expiry must drop it, and the status is stable in all other cycles. What the assertions cannot show is the full tick-count length of a window. The same goes for the effect of crossings spaced closer than the window, the zero-timeout case, and a write racing a crossing. These only show up when the bench's behavioural model is compared with the design over whole scenarios.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
    // Which source reloads the down-counter in a given cycle
    typedef enum logic [1:0] {
        LOAD_NONE  = 2'd0,
        LOAD_WRITE = 2'd1,
        LOAD_CROSS = 2'd2
    } load_src_e;

    localparam int unsigned ZCW_DEF_W = 12;
endpackage

// File: rtl/zcw_limit_reg.sv
module zcw_limit_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] limit_o
);
    localparam logic [W-1:0] RST_VAL = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] lim;
    } lim_state_t;

    lim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.lim = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lim <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign limit_o = st_q.lim;

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (limit_o == $past(wdata_i)));
endmodule

// File: rtl/zcw_countdown.sv
module zcw_countdown
    import zcw_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         zc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);
    localparam logic [W-1:0] CNT_RST = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } cd_state_t;

    cd_state_t st_d, st_q;
    load_src_e load_src;
    logic      expire;

    // A write takes priority over a crossing (R10)
    always_comb begin
        if (wr_i) begin
            load_src = LOAD_WRITE;
        end else if (zc_i) begin
            load_src = LOAD_CROSS;
        end else begin
            load_src = LOAD_NONE;
        end
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        unique case (load_src)
            LOAD_WRITE: begin
                st_d.cnt   = wdata_i;
                st_d.armed = 1'b1;
            end
            LOAD_CROSS: begin
                st_d.cnt   = limit_i;
                st_d.armed = 1'b1;
            end
            default: begin
                if (tick_i && st_q.armed && (st_q.cnt <= CNT_ONE)) begin
                    expire     = 1'b1;
                    st_d.cnt   = CNT_ZERO;
                    st_d.armed = 1'b0;
                end else if (tick_i && (st_q.cnt != CNT_ZERO)) begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= CNT_RST;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = expire;

    assert_write_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.cnt == $past(wdata_i)) && st_q.armed);

    assert_cross_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_i && !wr_i) |=> (st_q.cnt == $past(limit_i)) && st_q.armed);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !wr_i && !zc_i) |=> (st_q.cnt == CNT_ZERO) && !expire_o);

    assert_single_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !st_q.armed);
endmodule

// File: rtl/zcw_status.sv
module zcw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic en_i,
    output logic stat_o,
    output logic irq_n_o
);
    typedef struct packed {
        logic flag;
    } stat_state_t;

    stat_state_t st_d, st_q;

    // Set wins over a clear in the same cycle (R9); enable never gates the set (R7)
    always_comb begin
        st_d = st_q;
        if (expire_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.flag;
    assign irq_n_o = ~(st_q.flag & en_i);

    assert_set_any_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> stat_o);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> (!stat_o && irq_n_o));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !expire_i) |=> $stable(stat_o));
endmodule

// File: rtl/zc_timeout_watchdog.sv
module zc_timeout_watchdog #(
    parameter int unsigned TMO_W = zcw_pkg::ZCW_DEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             zc_i,
    input  logic             tmo_wr_i,
    input  logic [TMO_W-1:0] tmo_wdata_i,
    output logic [TMO_W-1:0] tmo_rdata_o,
    input  logic             irq_en_i,
    input  logic             stat_clr_i,
    output logic             stat_o,
    output logic             irq_n_o
);
    logic [TMO_W-1:0] limit_q;
    logic             expire;

    zcw_limit_reg #(.W(TMO_W)) limit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tmo_wr_i),
        .wdata_i (tmo_wdata_i),
        .limit_o (limit_q)
    );

    zcw_countdown #(.W(TMO_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .zc_i     (zc_i),
        .wr_i     (tmo_wr_i),
        .wdata_i  (tmo_wdata_i),
        .limit_i  (limit_q),
        .expire_o (expire)
    );

    zcw_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (stat_clr_i),
        .en_i     (irq_en_i),
        .stat_o   (stat_o),
        .irq_n_o  (irq_n_o)
    );

    assign tmo_rdata_o = limit_q;

    assert_no_tick_no_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !stat_o && !stat_clr_i) |=> !stat_o);

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && irq_en_i) |-> !irq_n_o);
endmodule

// File: tb/zc_timeout_watchdog_tb_top.sv
module zc_timeout_watchdog_tb_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         zc = 1'b0;
    logic         wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         en = 1'b1;
    logic         clr = 1'b0;
    logic         stat;
    logic         irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    zc_timeout_watchdog #(.TMO_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .zc_i(zc),
        .tmo_wr_i(wr), .tmo_wdata_i(wdata), .tmo_rdata_o(rdata),
        .irq_en_i(en), .stat_clr_i(clr), .stat_o(stat), .irq_n_o(irq_n)
    );

    // Behavioural reference model
    int m_lim, m_cnt, m_st;
    bit m_arm;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lim = 4095; m_cnt = 4095; m_arm = 1; m_st = 0;
        end else begin
            bit fire;
            fire = tick && m_arm && (m_cnt <= 1) && !wr && !zc;
            if (fire) m_st = 1;
            else if (clr) m_st = 0;
            if (wr) begin m_cnt = int'(wdata); m_arm = 1; end
            else if (zc) begin m_cnt = m_lim; m_arm = 1; end
            else if (fire) begin m_cnt = 0; m_arm = 0; end
            else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
            if (wr) m_lim = int'(wdata);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 readback", int'(rdata), m_lim);
            check("R5 status", int'(stat), m_st);
            check("R8 irq", int'(irq_n), (m_st != 0 && en) ? 0 : 1);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_val(input int v);
        wr = 1; wdata = W'(v);
        cyc(1);
        wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(2);
        rst_n = 1;
        cyc(1);
        check("R1 reset limit", int'(rdata), 4095);
        check("R1 reset status", int'(stat), 0);
        check("R1 reset irq", int'(irq_n), 1);

        // R2 / R3: timeout of 5 ticks
        wr_val(5);
        check("R2 stored", int'(rdata), 5);
        cyc(4);
        check("R3 before Nth tick", int'(stat), 0);
        cyc(1);
        check("R3 at Nth tick", int'(stat), 1);
        check("R8 irq low", int'(irq_n), 0);

        // R8: mask follows enable within the cycle
        en = 0; #1;
        check("R8 masked", int'(irq_n), 1);
        en = 1; #1;
        check("R8 unmasked", int'(irq_n), 0);

        // R9 clear, R5 no re-fire while idle
        clr = 1; cyc(1); clr = 0;
        check("R9 cleared", int'(stat), 0);
        check("R9 irq released", int'(irq_n), 1);
        cyc(20);
        check("R5 idle no refire", int'(stat), 0);

        // R3: crossings every 3 ticks keep it quiet
        for (int i = 0; i < 10; i++) begin
            zc = 1; cyc(1); zc = 0; cyc(2);
        end
        check("R3 crossings keep quiet", int'(stat), 0);
        cyc(10);
        check("R3 fires after crossings stop", int'(stat), 1);

        // R9: set wins over simultaneous clear
        clr = 1;
        wr_val(2);
        check("R9 clear", int'(stat), 0);
        cyc(2);
        check("R9 set wins", int'(stat), 1);
        cyc(1);
        check("R9 clear after", int'(stat), 0);
        clr = 0;

        // R4: timeout of zero
        wr_val(0);
        cyc(1);
        check("R4 zero timeout", int'(stat), 1);
        clr = 1; cyc(1); clr = 0;

        // R10: write beats crossing
        zc = 1; wr_val(3); zc = 0;
        cyc(2);
        check("R10 write wins", int'(stat), 0);
        cyc(1);
        check("R10 write window", int'(stat), 1);
        clr = 1; cyc(1); clr = 0;

        // R6 with R7: write restarts mid-count, enable off
        en = 0;
        wr_val(6);
        zc = 1; cyc(1); zc = 0;
        cyc(4);
        wr_val(6);
        cyc(5);
        check("R6 restart", int'(stat), 0);
        cyc(1);
        check("R6 fire after restart", int'(stat), 1);
        check("R7 status with enable off", int'(stat), 1);
        check("R7 irq masked", int'(irq_n), 1);
        en = 1; #1;
        check("R8 late enable", int'(irq_n), 0);
        clr = 1; cyc(1); clr = 0;

        // Slow timebase with sporadic crossings (model compare)
        for (int i = 0; i < 400; i++) begin
            tick = (i % 3) == 0;
            zc = (i % 37) == 5;
            clr = (i % 53) == 7;
            en = (i % 90) < 60;
            if ((i % 131) == 3) begin wr = 1; wdata = W'(i % 17); end
            cyc(1);
            wr = 0;
        end
        tick = 1; zc = 0; clr = 0; en = 1;

        // R1: default window after a fresh reset
        rst_n = 0; cyc(1); rst_n = 1;
        cyc(4000);
        check("R1 default window open", int'(stat), 0);
        cyc(200);
        check("R1 default window expired", int'(stat), 1);
        finish_run();
    end
endmodule